// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short queue of 8-bit completion records from a transmit engine. Each time a frame finishes, the engine presents one push carrying four flags: interrupt-on-success requested, jabber, underrun and too many collisions. The block stores the record and shows the oldest stored record on a byte port for the host.

A host write strobe to that port removes the record being shown. Reading the port never changes it. When a push arrives and there is no room, the record is lost. The lost record is then reported through a dedicated overflow bit in the record currently being shown.

A jabber or underrun record sets a sticky fatal indication, which keeps the transmitter disabled. A transmit-reset command or a global-reset command clears the stack, the overflow mark and the fatal indication. Qualifying records also raise a one-cycle completion event for the interrupt logic.

Top module: `tx_stat_stack`

## Requirements
- R1: While and right after reset, `stat_byte` is 0x00, `tx_fatal` is 0 and `txc_evt` is 0.
- R2: A shown record is encoded as: bit7 = 1 (complete), bit6 = interrupt requested, bit5 = jabber, bit4 = underrun, bit3 = maximum collisions, bit2 = overflow mark, and bits 1:0 = 0.
- R3: The stack holds `DEPTH` records (default 4) and shows them oldest first. The record of a push appears on `stat_byte` in the cycle after the clock edge that samples it, if the stack was empty.
- R4: A `host_wr` strobe removes the shown record at the next edge. A strobe while the stack is empty changes nothing.
- R5: A push while the stack is full, with no removal in the same cycle, is dropped. The overflow mark (bit2) then reads 1 on the shown record until that record is removed. The records after it show bit2 = 0.
- R6: A push and a removal in the same cycle with the stack full both take effect, and no overflow is marked.
- R7: Any push with the jabber or underrun flag set, whether stored or dropped, sets `tx_fatal` one edge later. `tx_fatal` then holds through removals until a reset command.
- R8: A command with `cmd_vld` = 1 and opcode 0x0B (transmit reset) or 0x00 (global reset) clears, at the next edge, every record, the overflow mark and `tx_fatal`. A push or removal in that same cycle is discarded. Any other opcode has no effect.
- R9: `txc_evt` is high for exactly the one cycle after each push whose interrupt, jabber, underrun or collision flag is set. This includes dropped pushes, but not pushes in the same cycle as a reset command.
- R10: When no record is stored, `stat_byte` reads 0x00, so its complete bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | Transmit engine presents a completion record |
| push_intr_req | input | 1 | Record flag: interrupt on success requested |
| push_jabber | input | 1 | Record flag: jabber error |
| push_underrun | input | 1 | Record flag: underrun error |
| push_maxcoll | input | 1 | Record flag: maximum collisions reached |
| host_wr | input | 1 | Host write to the status port; removes the shown record |
| cmd_vld | input | 1 | A command opcode is presented |
| cmd_op | input | 5 | Command opcode |
| stat_byte | output | 8 | Oldest record, or 0x00 when empty |
| tx_fatal | output | 1 | Transmitter must stay disabled until reset command |
| txc_evt | output | 1 | One-cycle completion event |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. The new shown record, its overflow mark, the fatal flag and the completion event all follow the edge that samples a push, removal or command. The bench drives all inputs on the falling edge and advances a behavioural queue model by one step for those inputs. On the next falling edge it compares all three outputs against the model. A delayed or early change therefore shows up as a mismatch in that very cycle.

// File: rtl/tx_stat_stack.sv
module tx_stat_stack #(
  parameter int DEPTH = 4,
  parameter logic [4:0] OP_TX_RST  = 5'h0B,
  parameter logic [4:0] OP_GLB_RST = 5'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_vld,
  input  logic       push_intr_req,
  input  logic       push_jabber,
  input  logic       push_underrun,
  input  logic       push_maxcoll,
  input  logic       host_wr,
  input  logic       cmd_vld,
  input  logic [4:0] cmd_op,
  output logic [7:0] stat_byte,
  output logic       tx_fatal,
  output logic       txc_evt
);
  // DEPTH must be a power of two, at least 2
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [3:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          ovf_flag;

  wire       clr    = cmd_vld && (cmd_op == OP_TX_RST || cmd_op == OP_GLB_RST);
  wire       empty  = (count == '0);
  wire       full   = (count == CW'(DEPTH));
  wire       pop    = host_wr && !empty && !clr;
  wire       acc    = push_vld && !clr && (!full || pop);
  wire       drop   = push_vld && !clr && full && !pop;
  wire [3:0] rec_in = {push_intr_req, push_jabber, push_underrun, push_maxcoll};
  wire       qual   = push_vld && !clr && (|rec_in);
  wire       fatal_in = push_vld && !clr && (push_jabber || push_underrun);

  always_ff @(posedge clk) begin
    if (acc) mem[wr_ptr] <= rec_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      ovf_flag <= 1'b0;
      tx_fatal <= 1'b0;
      txc_evt  <= 1'b0;
    end else if (clr) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      ovf_flag <= 1'b0;
      tx_fatal <= 1'b0;
      txc_evt  <= 1'b0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + PW'(1);
      if (acc) wr_ptr <= wr_ptr + PW'(1);
      case ({acc, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (drop)     ovf_flag <= 1'b1;
      else if (pop) ovf_flag <= 1'b0;
      if (fatal_in) tx_fatal <= 1'b1;
      txc_evt <= qual;
    end
  end

  assign stat_byte = empty ? 8'h00 : {1'b1, mem[rd_ptr], ovf_flag, 2'b00};

  // R3
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (stat_byte == 8'h00));

  // R5
  overflow_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && full && !host_wr && !clr) |=> stat_byte[2]);

  // R7
  fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fatal && !clr) |=> tx_fatal);

  // R8
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat_byte == 8'h00 && !tx_fatal && !txc_evt));

  // R9
  event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && !clr && (push_intr_req || push_jabber || push_underrun || push_maxcoll))
      |=> txc_evt);

  // R6
  swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_vld && host_wr && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: tb/tx_stat_stack_tb.sv
module tx_stat_stack_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_vld = 0, push_intr_req = 0, push_jabber = 0, push_underrun = 0, push_maxcoll = 0;
  logic       host_wr = 0, cmd_vld = 0;
  logic [4:0] cmd_op = 5'h1F;
  logic [7:0] stat_byte;
  logic       tx_fatal, txc_evt;

  int total = 0;
  int bad = 0;

  logic [3:0] q[$];
  bit m_ovf = 0, m_fatal = 0, m_evt = 0;

  always #2 clk = ~clk;

  tx_stat_stack u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_vld(push_vld), .push_intr_req(push_intr_req), .push_jabber(push_jabber),
    .push_underrun(push_underrun), .push_maxcoll(push_maxcoll),
    .host_wr(host_wr), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .stat_byte(stat_byte), .tx_fatal(tx_fatal), .txc_evt(txc_evt));

  function automatic logic [7:0] exp_byte();
    if (q.size() == 0) return 8'h00;
    return {1'b1, q[0], m_ovf, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, stat_byte, exp_byte(), "stat_byte");
    chk(tag, {7'd0, tx_fatal}, {7'd0, m_fatal}, "tx_fatal");
    chk(tag, {7'd0, txc_evt}, {7'd0, m_evt}, "txc_evt");
  endtask

  task automatic step(input bit p, input logic [3:0] rec, input bit wr,
                      input bit cv, input logic [4:0] op, input string tag);
    bit clr;
    bit popping;
    push_vld = p; {push_intr_req, push_jabber, push_underrun, push_maxcoll} = rec;
    host_wr = wr; cmd_vld = cv; cmd_op = op;
    clr = cv && (op == 5'h0B || op == 5'h00);
    if (clr) begin
      q.delete(); m_ovf = 0; m_fatal = 0; m_evt = 0;
    end else begin
      m_evt = p && (rec != 4'h0);
      if (p && (rec[2] || rec[1])) m_fatal = 1;
      popping = wr && q.size() > 0;
      if (popping) begin void'(q.pop_front()); m_ovf = 0; end
      if (p) begin
        if (q.size() < 4) q.push_back(rec);
        else m_ovf = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 4'h0, 0, 0, 5'h1F, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    idle("R10");

    // R2, R9: single records of each flag pattern
    step(1, 4'b1000, 0, 0, 5'h1F, "R2_intr");
    step(0, 4'h0, 1, 0, 5'h1F, "R4_pop");
    step(1, 4'b0001, 0, 0, 5'h1F, "R2_coll");
    step(0, 4'h0, 1, 0, 5'h1F, "R4_pop");
    step(1, 4'b0000, 0, 0, 5'h1F, "R9_noevt");
    idle("R2_plain");
    step(0, 4'h0, 1, 0, 5'h1F, "R10_empty");

    // R4: removal on empty does nothing
    step(0, 4'h0, 1, 0, 5'h1F, "R4_emptypop");
    idle("R4_emptypop");

    // R3: fill to depth, drain oldest first
    step(1, 4'b1001, 0, 0, 5'h1F, "R3_fill");
    step(1, 4'b0000, 0, 0, 5'h1F, "R3_fill");
    step(1, 4'b1000, 0, 0, 5'h1F, "R3_fill");
    step(1, 4'b0001, 0, 0, 5'h1F, "R3_fill");
    idle("R3_hold");

    // R5: overflow while full
    step(1, 4'b1000, 0, 0, 5'h1F, "R5_drop");
    step(1, 4'b0000, 0, 0, 5'h1F, "R5_drop2");
    step(0, 4'h0, 1, 0, 5'h1F, "R5_clear");
    step(0, 4'h0, 1, 0, 5'h1F, "R3_drain");

    // R6: push and removal together at full
    step(1, 4'b1001, 0, 0, 5'h1F, "R6_refill");
    step(1, 4'b1000, 0, 0, 5'h1F, "R6_refill");
    step(1, 4'b0001, 1, 0, 5'h1F, "R6_swap");
    step(1, 4'b1001, 1, 0, 5'h1F, "R6_swap");
    for (int i = 0; i < 5; i++) step(0, 4'h0, 1, 0, 5'h1F, "R3_drain");

    // R7: fatal latch from jabber, held through removals
    step(1, 4'b0100, 0, 0, 5'h1F, "R7_jabber");
    step(0, 4'h0, 1, 0, 5'h1F, "R7_hold");
    idle("R7_hold");

    // R8: other opcode ignored, transmit reset clears
    step(1, 4'b0001, 0, 1, 5'h05, "R8_other");
    step(0, 4'h0, 0, 1, 5'h01, "R8_other");
    step(0, 4'h0, 0, 1, 5'h0B, "R8_txrst");
    idle("R8_after");

    // R7/R8: underrun then global reset with push in same cycle
    step(1, 4'b0010, 0, 0, 5'h1F, "R7_underrun");
    step(1, 4'b1000, 0, 0, 5'h1F, "R8_fill");
    step(1, 4'b1100, 1, 1, 5'h00, "R8_glbrst");
    idle("R8_after");

    // R7: fatal set by a dropped record
    for (int i = 0; i < 4; i++) step(1, 4'b0001, 0, 0, 5'h1F, "R5_fill");
    step(1, 4'b0010, 0, 0, 5'h1F, "R7_dropped");
    step(0, 4'h0, 1, 0, 5'h1F, "R5_clear");
    step(0, 4'h0, 0, 1, 5'h0B, "R8_txrst");
    idle("R1_final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule